// File: doc/BRIEF.md
# Wide Switch Register Access over MDIO

This block lets a host read or write a 32-bit switch register that can only be reached through 16-bit Clause 22 MDIO management frames. The host presents a byte address, an operation code and write data on a valid/ready request. The block then runs a fixed series of 64-bit frames on MDC/MDIO and pulses a done strobe when the last frame has completed. Read results come back on a 32-bit data output.

Every access opens with a page-select write. The word index is the byte address with its two lowest bits removed. The page register sits at a fixed management address and takes the word index shifted right by seven. Two data frames follow, one per 16-bit half, and both go to a PHY address chosen by three bits of the word index. Reads fetch the low half first. Writes send the high half first, so the low-half write is always the final frame. A third operation reads the register, ORs the supplied bits into the value and writes it back. The block generates MDC from the system clock with a parameterised divider and accepts a new request only after the previous one has finished.

Top module: `sw_reg_mdio_bridge`

## Requirements
- R1: The word index is the byte address shifted right by two. Address bits [1:0] have no effect on any frame.
- R2: The first frame of every access writes the value (word index >> 7), zero-extended to 16 bits, to PHY address 0x1F, register 0x10.
- R3: Data frames use PHY address 0x10 | word_index[6:4]. The low half is held in register (word_index << 1) & 0x1E and the high half in the register one above it.
- R4: Operation code 00 (read) issues page write, read of the low register, then read of the high register. rsp_rdata is {high, low} when rsp_done pulses.
- R5: Operation code 01 (write) issues page write, write of req_wdata[31:16] to the high register, then write of req_wdata[15:0] to the low register.
- R6: Operation code 10 (set bits) performs the full read sequence and then the full write sequence. It writes back (old | req_wdata) and returns the old value on rsp_rdata.
- R7: Each frame is 32 ones, start 01, opcode 01 (write) or 10 (read), 5-bit PHY address, 5-bit register and a 2-bit turnaround followed by 16 data bits, all MSB first. Writes drive turnaround 10 with mdio_oe high throughout. Reads hold mdio_oe high for the first 46 bits and low for the turnaround and data.
- R8: MDC stays high and low for CLK_DIV system cycles each. mdio_o and mdio_oe change only while MDC is low, and mdio_i is sampled as MDC rises. When idle, MDC is low and mdio_oe is low.
- R9: req_ready drops in the cycle after a request is accepted and stays low until rsp_done. A request raised while busy is not taken. rsp_done lasts one cycle, with req_ready high in that cycle.
- R10: Operation code 11 behaves exactly as a read.
- R11: After reset req_ready is 1, rsp_done is 0, mdc is 0, mdio_oe is 0 and mdio_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 00 read, 01 write, 10 set bits, 11 read |
| req_addr | input | ADDR_W | Byte address of the switch register |
| req_wdata | input | 32 | Write data or bits to set |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 32 | Read result, valid at rsp_done for reads and set-bits |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench builds the block with CLK_DIV = 3 and ADDR_W = 18. The odd divider shows that the high and low phases each last the full divider count rather than a plain toggle. The 18-bit address gives page values up to nine bits wide and word indexes with bits [6:4] all set, which exercises the top data PHY address 0x17 and the top even register 0x1E. A behavioural MDIO target keeps register contents, so the bench can check written halves by reading them back and can verify the set-bits merge against the stored old value.

// File: rtl/sw_reg_mdio_bridge.sv
module sw_reg_mdio_bridge #(
  parameter int ADDR_W  = 18,
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_done,
  output logic [31:0]       rsp_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  localparam int WIDX_W = ADDR_W - 2;
  localparam int DIV_W  = $clog2(CLK_DIV + 1);
  localparam logic [1:0] OP_WR  = 2'b01;
  localparam logic [1:0] OP_SET = 2'b10;

  function automatic logic [63:0] mk_frame(input logic wr, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, phy, rg,
            wr ? 2'b10 : 2'b00, wr ? d : 16'h0000};
  endfunction

  // step 0/3 page, 1/2 read low/high, 4/5 write high/low
  function automatic logic [63:0] step_frame(input logic [2:0] k, input logic [WIDX_W-1:0] w,
                                             input logic [31:0] v);
    logic [4:0]  dphy;
    logic [4:0]  ereg;
    logic [15:0] pg;
    dphy = {2'b10, w[6:4]};
    ereg = {w[3:0], 1'b0};
    pg   = 16'(w >> 7);
    case (k)
      3'd1:    return mk_frame(1'b0, dphy, ereg, 16'h0000);
      3'd2:    return mk_frame(1'b0, dphy, ereg | 5'd1, 16'h0000);
      3'd4:    return mk_frame(1'b1, dphy, ereg | 5'd1, v[31:16]);
      3'd5:    return mk_frame(1'b1, dphy, ereg, v[15:0]);
      default: return mk_frame(1'b1, 5'h1F, 5'h10, pg);
    endcase
  endfunction

  logic              busy;
  logic [2:0]        k, last_k;
  logic [5:0]        bit_cnt;
  logic [63:0]       sr;
  logic [DIV_W-1:0]  div_cnt;
  logic              mdc_r, done_r;
  logic [31:0]       rd_data;
  logic [1:0]        op_r;
  logic [WIDX_W-1:0] widx_r;
  logic [31:0]       wdata_r;

  logic              tick, rd_frame;
  logic [31:0]       wval;
  logic [2:0]        start_k, end_k;

  assign tick      = busy && (div_cnt == DIV_W'(CLK_DIV - 1));
  assign rd_frame  = (k == 3'd1) || (k == 3'd2);
  assign wval      = (op_r == OP_WR) ? wdata_r : (rd_data | wdata_r);
  assign start_k   = (req_op == OP_WR) ? 3'd3 : 3'd0;
  assign end_k     = (req_op == OP_WR || req_op == OP_SET) ? 3'd5 : 3'd2;

  assign req_ready = !busy;
  assign rsp_done  = done_r;
  assign rsp_rdata = rd_data;
  assign mdc       = mdc_r;
  assign mdio_o    = busy ? sr[63] : 1'b1;
  assign mdio_oe   = busy && (!rd_frame || bit_cnt < 6'd46);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      k       <= 3'd0;
      last_k  <= 3'd0;
      bit_cnt <= 6'd0;
      sr      <= 64'h0;
      div_cnt <= '0;
      mdc_r   <= 1'b0;
      done_r  <= 1'b0;
      rd_data <= 32'h0;
      op_r    <= 2'b00;
      widx_r  <= '0;
      wdata_r <= 32'h0;
    end else begin
      done_r <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy    <= 1'b1;
          op_r    <= req_op;
          widx_r  <= req_addr[ADDR_W-1:2];
          wdata_r <= req_wdata;
          k       <= start_k;
          last_k  <= end_k;
          sr      <= step_frame(start_k, req_addr[ADDR_W-1:2], req_wdata);
          bit_cnt <= 6'd0;
          div_cnt <= '0;
          mdc_r   <= 1'b0;
        end
      end else if (tick) begin
        div_cnt <= '0;
        mdc_r   <= !mdc_r;
        if (!mdc_r) begin
          if (rd_frame && bit_cnt >= 6'd48) begin
            if (k == 3'd1) rd_data[15:0]  <= {rd_data[14:0], mdio_i};
            else           rd_data[31:16] <= {rd_data[30:16], mdio_i};
          end
        end else if (bit_cnt == 6'd63) begin
          if (k == last_k) begin
            busy   <= 1'b0;
            done_r <= 1'b1;
          end else begin
            k       <= k + 3'd1;
            sr      <= step_frame(k + 3'd1, widx_r, wval);
            bit_cnt <= 6'd0;
          end
        end else begin
          sr      <= {sr[62:0], 1'b0};
          bit_cnt <= bit_cnt + 6'd1;
        end
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end

  p_accept_drops_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_done_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mdc && !mdio_oe);
  p_hold_while_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> $stable(mdio_o) && $stable(mdio_oe));

endmodule

// File: tb/sw_reg_mdio_bridge_bench.sv
module sw_reg_mdio_bridge_bench;
  localparam int AW = 18;
  localparam int CD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = 32'h0;
  logic req_ready, rsp_done, mdc, mdio_o, mdio_oe;
  logic [31:0] rsp_rdata;
  logic mdio_i = 1'b1;

  always #10 clk = ~clk;

  sw_reg_mdio_bridge #(.ADDR_W(AW), .CLK_DIV(CD)) u_sw_reg_mdio_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural target register file
  logic [15:0] mem [int];
  function automatic logic [15:0] get_reg(input int key);
    if (mem.exists(key)) return mem[key];
    return 16'(key * 257) ^ 16'hA5C3;
  endfunction

  // scoreboard: {wr, phy, reg, data}
  logic [26:0] exp_q[$];
  string tag_q[$];

  function automatic void push(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                               input logic [15:0] d, input string tag);
    exp_q.push_back({wr, phy, rg, wr ? d : 16'h0});
    tag_q.push_back(tag);
  endfunction

  // target / monitor
  int bc = 0;
  logic [63:0] f = 64'h0;
  bit fmt_bad = 0;
  always @(posedge mdc) begin
    f[63-bc] = mdio_o;
    if (bc < 46 && !mdio_oe) fmt_bad = 1;
    if (bc >= 46) begin
      if (f[29:28] == 2'b10 && mdio_oe) fmt_bad = 1;
      if (f[29:28] != 2'b10 && !mdio_oe) fmt_bad = 1;
    end
    if (bc == 63) begin
      logic wr;
      logic [26:0] obs;
      wr = (f[29:28] == 2'b01);
      if (f[63:32] != 32'hFFFF_FFFF || f[31:30] != 2'b01 ||
          !(f[29:28] == 2'b01 || f[29:28] == 2'b10) || (wr && f[17:16] != 2'b10))
        fmt_bad = 1;
      chk(!fmt_bad, "R7", "frame format", f, f);
      obs = {wr, f[27:23], f[22:18], wr ? f[15:0] : 16'h0};
      if (wr) mem[int'(f[27:18])] = f[15:0];
      if (exp_q.size() == 0) chk(0, "R9", "unexpected frame", 64'(obs), 64'h0);
      else begin
        logic [26:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(obs == e, t, "frame", 64'(obs), 64'(e));
      end
      bc = 0;
      fmt_bad = 0;
    end else bc++;
  end

  always @(negedge mdc) begin
    if (bc >= 48 && f[29:28] == 2'b10) begin
      logic [15:0] rv;
      rv = get_reg(int'(f[27:18]));
      mdio_i = rv[63-bc];
    end
  end

  // timing observers
  int hi_run = 0, period_viol = 0, hold_viol = 0, done_viol = 0, idle_viol = 0;
  logic prev_mdc = 0, prev_o = 1, prev_oe = 0, prev_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mdc) hi_run++;
      else if (hi_run != 0) begin
        if (hi_run != CD) period_viol++;
        hi_run = 0;
      end
      if (mdc && prev_mdc && (mdio_o != prev_o || mdio_oe != prev_oe)) hold_viol++;
      if (rsp_done && prev_done) done_viol++;
      if (rsp_done && !req_ready) done_viol++;
      if (req_ready && (mdc || mdio_oe)) idle_viol++;
    end
    prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe; prev_done = rsp_done;
  end

  task automatic access(input logic [1:0] op, input logic [AW-1:0] addr,
                        input logic [31:0] wd, input bit intrude,
                        output logic [31:0] got, output logic [31:0] exp_rd);
    logic [15:0] widx, pg;
    logic [4:0] phy, ev, od;
    logic [31:0] nv;
    widx = 16'(addr >> 2);
    pg   = widx >> 7;
    phy  = {2'b10, widx[6:4]};
    ev   = {widx[3:0], 1'b0};
    od   = ev | 5'd1;
    exp_rd = {get_reg(int'({phy, od})), get_reg(int'({phy, ev}))};
    push(1'b1, 5'h1F, 5'h10, pg, "R2");
    if (op != 2'b01) begin
      push(1'b0, phy, ev, 16'h0, "R3 R4");
      push(1'b0, phy, od, 16'h0, "R3 R4");
    end
    if (op == 2'b01 || op == 2'b10) begin
      nv = (op == 2'b01) ? wd : (exp_rd | wd);
      if (op == 2'b10) push(1'b1, 5'h1F, 5'h10, pg, "R6");
      push(1'b1, phy, od, nv[31:16], "R5");
      push(1'b1, phy, ev, nv[15:0], "R5");
    end
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b0, "R9", "ready after accept", 64'(req_ready), 64'h0);
    if (intrude) begin
      req_op = 2'b00; req_addr = 18'h0_0100;
      repeat (200) @(negedge clk);
      chk(req_ready == 1'b0, "R9", "ready while busy", 64'(req_ready), 64'h0);
    end
    req_valid = 1'b0;
    while (!rsp_done) @(negedge clk);
    got = rsp_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R9", "watchdog expired", 64'h0, 64'h1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] got, er;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !rsp_done && !mdc && !mdio_oe && mdio_o, "R11", "reset state",
        64'({req_ready, rsp_done, mdc, mdio_oe, mdio_o}), 64'b10001);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    access(2'b01, 18'h2_F3C8, 32'hDEAD_BEEF, 0, got, er);
    access(2'b00, 18'h2_F3C8, 32'h0, 0, got, er);
    chk(got == 32'hDEAD_BEEF, "R4", "read back after write", 64'(got), 64'hDEAD_BEEF);

    access(2'b00, 18'h0_0070, 32'h0, 0, got, er);
    chk(got == er, "R4", "read of untouched register", 64'(got), 64'(er));

    access(2'b01, 18'h1_2347, 32'h1357_9BDF, 0, got, er);
    access(2'b00, 18'h1_2344, 32'h0, 0, got, er);
    chk(got == 32'h1357_9BDF, "R1", "low address bits ignored", 64'(got), 64'h1357_9BDF);

    access(2'b10, 18'h2_F3C8, 32'h0000_0F10, 0, got, er);
    chk(got == 32'hDEAD_BEEF, "R6", "set-bits returns old value", 64'(got), 64'hDEAD_BEEF);
    access(2'b00, 18'h2_F3C8, 32'h0, 0, got, er);
    chk(got == 32'hDEAD_BFFF, "R6", "set-bits merged value", 64'(got), 64'hDEAD_BFFF);

    access(2'b11, 18'h0_01FC, 32'hFFFF_FFFF, 0, got, er);
    chk(got == er, "R10", "code 11 reads", 64'(got), 64'(er));

    access(2'b01, 18'h3_FFFC, 32'hA5A5_0F0F, 1, got, er);
    access(2'b00, 18'h3_FFFC, 32'h0, 0, got, er);
    chk(got == 32'hA5A5_0F0F, "R5", "write at top page", 64'(got), 64'hA5A5_0F0F);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "all expected frames seen", 64'(exp_q.size()), 64'h0);
    chk(period_viol == 0, "R8", "mdc high phase length", 64'(period_viol), 64'h0);
    chk(hold_viol == 0, "R8", "mdio change while mdc high", 64'(hold_viol), 64'h0);
    chk(done_viol == 0, "R9", "done pulse shape", 64'(done_viol), 64'h0);
    chk(idle_viol == 0, "R8", "idle bus quiet", 64'(idle_viol), 64'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule